// File: doc/BRIEF.md
# Baud-Rate Reload Down-Counter

This block produces the bit-rate timing for one serial channel. It is a 12-bit down-counter that reloads itself from a programmable value. Software sets the 12-bit reload value through a byte-wide register port and then sets a run bit. Setting the run bit copies the reload value into the counter. From then on the counter steps down by one every clock. When it would go below zero it takes the reload value again, so one period is the reload value plus one clocks.

Each underflow raises a tick that lasts one clock. A baud clock output changes level on every underflow, so one full baud clock cycle spans two counter periods. The live count can be read at any time without disturbing counting. Reading the low count byte also latches the count's upper bits into a holding register. A later high-byte read returns the latched bits, so a low/high read pair always comes from the same count value.

Top module: `baud_reload_timer`

## Requirements
- R1: After reset the counter, the reload value, the run bit, the holding register, `tick` and `baudClk` are all zero, and every register address reads 0x00.
- R2: Address 0 holds reload bits [7:0] and address 1 holds reload bits [11:8] in data bits [3:0]. Both can be read back. Bits [7:4] written to address 1 are discarded and read as 0.
- R3: While running, the count drops by exactly one per clock for as long as it is not zero.
- R4: While running, a count of zero is replaced on the next clock by the current reload value, giving a period of reload+1 clocks.
- R5: Writing address 2 with data bit 0 = 1 loads the reload value into the counter on that clock edge and sets the run bit. This applies even when the timer is already running.
- R6: Writing address 2 with data bit 0 = 0 clears the run bit. The count then holds its value, and the reload registers can be rewritten without affecting the held count.
- R7: Address 3 reads the live count bits [7:0]. Address 4 reads the held count bits [11:8] in data bits [3:0], with data bits [7:4] always 0.
- R8: Each read of address 3 latches count bits [11:8] as they stood before that clock edge. Later reads of address 4 return the latched value, even after the live count has changed.
- R9: `tick` is high for exactly the clock following each underflow and is low otherwise. `baudClk` changes level at each underflow and nowhere else.
- R10: Address 2 reads the run bit in data bit 0, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of address 3 latches the holding register) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| tick | output | 1 | One-clock pulse per underflow |
| baudClk | output | 1 | Level that changes on every underflow |

## Verification
Register writes, a start and a stop all take effect at the clock edge that samples them. The count therefore shows the new value in the cycle right after that edge. `tick` and the `baudClk` change appear in the cycle after the edge that sees a zero count, which is the same cycle in which the count shows the reload value. `rdData` is combinational, so it reflects state after the latest edge under the address currently applied. The holding register changes only at the edge that samples a read of address 3. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge. It compares `tick`, `baudClk` and any active read 2 ns after that rising edge, so each expected value is due in exactly the cycle it is sampled.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd4;

  typedef struct packed {
    logic start;    // load reload value, begin running
    logic countEn;  // step the counter this cycle
    logic capture;  // latch upper count bits into holding register
  } tmrStrobe_t;
endpackage

// File: rtl/baud_timer_ctrl.sv
module baud_timer_ctrl
  import baud_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-DATA_W-1:0] snapHi,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  reloadVal,
  output tmrStrobe_t        strobe
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] reloadLo;
  logic [HI_W-1:0]   reloadHi;
  logic              runQ;
  logic              ctrlWr;

  assign ctrlWr = wrEn && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadLo <= '0;
      reloadHi <= '0;
      runQ     <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        A_RLD_LO: reloadLo <= wrData;
        A_RLD_HI: reloadHi <= wrData[HI_W-1:0];
        A_CTRL:   runQ     <= wrData[0];
        default:  ;
      endcase
    end
  end

  assign reloadVal = {reloadHi, reloadLo};

  always_comb begin
    strobe.start   = ctrlWr && wrData[0];
    strobe.countEn = runQ && !ctrlWr;
    strobe.capture = rdEn && (addr == A_CNT_LO);
  end

  always_comb begin
    case (addr)
      A_RLD_LO: rdData = reloadLo;
      A_RLD_HI: rdData = {{PAD_W{1'b0}}, reloadHi};
      A_CTRL:   rdData = {{(DATA_W-1){1'b0}}, runQ};
      A_CNT_LO: rdData = countVal[DATA_W-1:0];
      A_CNT_HI: rdData = {{PAD_W{1'b0}}, snapHi};
      default:  rdData = '0;
    endcase
  end

  // R5: a start write leaves the run bit set
  p_run_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL && wrData[0]) |=> runQ);

  // R6: a stop write leaves the run bit clear
  p_run_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL && !wrData[0]) |=> !runQ);

  // R7: upper bits of the held-count read are zero
  p_hi_pad_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_CNT_HI) |-> (rdData[DATA_W-1:HI_W] == '0));
endmodule

// File: rtl/baud_timer_dp.sv
module baud_timer_dp
  import baud_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-DATA_W-1:0] snapHi,
  output logic             tick,
  output logic             baudClk
);
  logic underflow;

  assign underflow = strobe.countEn && (countVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      tick     <= 1'b0;
      baudClk  <= 1'b0;
    end else begin
      tick <= underflow;
      if (underflow) baudClk <= ~baudClk;
      if (strobe.start)       countVal <= reloadVal;
      else if (underflow)     countVal <= reloadVal;
      else if (strobe.countEn) countVal <= countVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              snapHi <= '0;
    else if (strobe.capture) snapHi <= countVal[CNT_W-1:DATA_W];
  end

  // R2 / R5: start copies the reload value
  p_start_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (countVal == $past(reloadVal)));

  // R3: one step down per clock while running and nonzero
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && countVal != '0) |=> (countVal == $past(countVal) - CNT_W'(1)));

  // R6: count holds while neither running nor starting
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.start) |=> $stable(countVal));

  // R9: baud level changes exactly when a tick is present
  p_baud_follows_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (baudClk != $past(baudClk)));

  p_baud_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> $stable(baudClk));
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
  import baud_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              tick,
  output logic              baudClk
);
  localparam int HI_W = CNT_W - DATA_W;

  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] countVal;
  logic [HI_W-1:0]  snapHi;

  baud_timer_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .countVal(countVal), .snapHi(snapHi),
    .rdData(rdData), .reloadVal(reloadVal), .strobe(strobe)
  );

  baud_timer_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .countVal(countVal), .snapHi(snapHi), .tick(tick), .baudClk(baudClk)
  );
endmodule

// File: tb/baud_reload_timer_tb.sv
module baud_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       tick, baudClk;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int mCount = 0, mReload = 0, mSnap = 0;
  bit mRun = 0, mTick = 0, mBaud = 0;

  always #4 clk = ~clk;  // 125 MHz

  baud_reload_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tick(tick), .baudClk(baudClk)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int expRead(int a);
    case (a)
      0: return mReload & 8'hFF;
      1: return (mReload >> 8) & 4'hF;
      2: return int'(mRun);
      3: return mCount & 8'hFF;
      4: return mSnap;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nextCount;
    bit nextTick;
    cycles++;
    if (!rstN) begin
      mCount = 0; mReload = 0; mSnap = 0; mRun = 0; mTick = 0; mBaud = 0;
    end else begin
      if (rdEn && addr == 3'd3) mSnap = (mCount >> 8) & 4'hF;
      nextCount = mCount;
      nextTick = 0;
      if (wrEn && addr == 3'd2 && wrData[0]) nextCount = mReload;
      else if (mRun && !(wrEn && addr == 3'd2)) begin
        if (mCount == 0) begin nextCount = mReload; nextTick = 1; mBaud = !mBaud; end
        else nextCount = mCount - 1;
      end
      mCount = nextCount;
      mTick = nextTick;
      if (wrEn) begin
        case (addr)
          3'd0: mReload = (mReload & 12'hF00) | wrData;
          3'd1: mReload = (mReload & 12'h0FF) | ((wrData & 8'h0F) << 8);
          3'd2: mRun = wrData[0];
          default: ;
        endcase
      end
      #2;
      chk("R9 tick", int'(tick), int'(mTick));
      chk("R9 baudClk", int'(baudClk), int'(mBaud));
      if (rdEn) chk(curReq, int'(rdData), expRead(int'(addr)));
    end
  end

  task automatic cyc(bit w, bit r, int a, int d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = 3'(a); wrData = 8'(d);
  endtask

  task automatic wr(int a, int d);
    cyc(1, 0, a, d);
  endtask

  task automatic rdN(int a, int n);
    for (int i = 0; i < n; i++) cyc(0, 1, a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    curReq = "R1 reset";
    chk("R1 tick", int'(tick), 0);
    chk("R1 baudClk", int'(baudClk), 0);
    rstN = 1'b1;
    for (int a = 0; a < 5; a++) rdN(a, 1);

    curReq = "R2 reload readback";
    wr(0, 8'h05); wr(1, 8'hF3);
    rdN(0, 1); rdN(1, 1);

    curReq = "R10 run bit";
    wr(2, 1); rdN(2, 1);
    curReq = "R3 count down";
    wr(0, 8'h05); wr(1, 8'h00); rdN(3, 6);
    curReq = "R5 start reload";
    wr(2, 1); rdN(3, 3);
    curReq = "R4 underflow reload";
    rdN(3, 20);

    curReq = "R6 stop hold";
    wr(2, 0); rdN(3, 4);
    wr(0, 8'h22); wr(1, 8'h01); rdN(3, 4); rdN(2, 1);

    curReq = "R8 snapshot";
    wr(0, 8'h00); wr(1, 8'h01);
    wr(2, 1);
    rdN(3, 1);
    rdN(4, 3);
    curReq = "R7 count high read";
    rdN(3, 1); rdN(4, 1);

    curReq = "R5 restart while running";
    wr(0, 8'h03); wr(1, 8'h00);
    rdN(3, 2); wr(2, 1); rdN(3, 10);

    curReq = "R9 reload zero";
    wr(0, 8'h00); wr(2, 1); rdN(3, 8);
    wr(2, 0); rdN(3, 3);

    @(negedge clk);
    wrEn = 0; rdEn = 0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule